// File: doc/BRIEF.md
# PWM Generator with Frame-Aligned Pulse Blanking

This block drives a fixed-frequency, edge-aligned PWM output and thins it in hardware. It emits a programmed number of normal pulses, then suppresses a programmed number of whole PWM periods, and repeats that pattern with no software action per cycle. A typical setting is two pulses followed by four quiet periods. A 16-bit up-counter forms each PWM period. A second, slower counter tracks which period of the current frame is running and forces the output low in the blanked part of the frame.

Blanking only starts and ends where a period wraps. The last pulse before a blanked stretch therefore keeps its full off time, and every blanked period adds exactly one full period of low output. The period, compare, pulse-count and blank-count inputs are sampled into holding registers only when a frame begins. Changing them in the middle of a frame cannot corrupt the pattern that is running. A one-clock strobe marks the first clock of every frame.

Top module: `pwm_frame_blanker`

## Requirements
- R1: The time base counts 0, 1, …, `period_in` and wraps to 0, so each PWM period lasts `period_in`+1 clocks.
- R2: In a pulse period the output is high from count 0 and goes low on the count equal to the compare value, so it is high for exactly `cmp_in` clocks.
- R3: A frame is `act_in` pulse periods followed by `blk_in` blanked periods, and frames repeat back to back without a gap.
- R4: In a blanked period the output is low on every clock of the period. Blanking begins and ends only at a period wrap.
- R5: Period, compare, pulse count and blank count are sampled only on the first clock of a frame. Changes made while a frame runs take effect from the next frame.
- R6: A compare value of 0 gives a constantly low pulse period. A compare value above the period gives a constantly high pulse period.
- R7: A pulse count of 0 keeps the output low at all times. A blank count of 0 gives ordinary continuous PWM.
- R8: `frame_start` is high for one clock: the first clock of each frame, where the counter is 0 and the first period of the frame begins.
- R9: While `rst` is high (synchronous) or `en` is low, both counters are cleared and both outputs are low. The first frame begins, with a pulse period, on the clock after the edge that samples `en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the block idle |
| period_in | input | 16 | Last count of the time base (period = value + 1 clocks) |
| cmp_in | input | 16 | Count at which the output falls in a pulse period |
| act_in | input | 8 | Pulse periods per frame |
| blk_in | input | 8 | Blanked periods per frame |
| pwm_out | output | 1 | PWM output |
| frame_start | output | 1 | One-clock strobe on the first clock of each frame |

## Verification
The embedded assertions check the following on every clock:
- the counter never passes the held period;
- the period index within a frame moves only at a wrap;
- the held settings stay unchanged except at a frame boundary;
- an idle block or a zero pulse count gives a low output;
- the frame strobe is never longer than one clock.

The bench checks the exact waveform against the requirements. That covers the pulse width for each compare value, the full off time before a blanked stretch, the alignment of the pulse and blank pattern across repeated frames, and the deferred effect of settings changed mid-frame. It does this with a cycle-by-cycle sweep over small periods, compare values and frame shapes.

// File: rtl/pwm_frame_blanker.sv
module pwm_frame_blanker #(
  parameter int CW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] cmp_in,
  input  logic [NW-1:0] act_in,
  input  logic [NW-1:0] blk_in,
  output logic          pwm_out,
  output logic          frame_start
);
  localparam int FW = NW + 1;

  logic          running;
  logic [CW-1:0] tb;
  logic [CW-1:0] per_q, cmp_q;
  logic [NW-1:0] act_q, blk_q;
  logic [FW-1:0] idx;

  wire [FW-1:0] flen    = {1'b0, act_q} + {1'b0, blk_q};
  wire          wrap    = (tb == per_q);
  wire          last    = (idx + 1'b1) >= flen;
  wire          reload  = !running || (wrap && last);
  wire          act_per = idx < {1'b0, act_q};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      running <= 1'b0;
      tb      <= '0;
      idx     <= '0;
    end else begin
      running <= 1'b1;
      tb      <= (!running || wrap) ? '0 : tb + 1'b1;
      if (reload)    idx <= '0;
      else if (wrap) idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      cmp_q <= '0;
      act_q <= '0;
      blk_q <= '0;
    end else if (en && reload) begin
      per_q <= period_in;
      cmp_q <= cmp_in;
      act_q <= act_in;
      blk_q <= blk_in;
    end
  end

  assign pwm_out     = running && act_per && (tb < cmp_q);
  assign frame_start = running && (tb == '0) && (idx == '0);

  a_r1_count_bounded: assert property (@(posedge clk) disable iff (rst)
    running |-> tb <= per_q);

  a_r1_wraps_to_zero: assert property (@(posedge clk) disable iff (rst)
    (running && en && tb == per_q) |=> tb == '0);

  a_r4_index_moves_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (running && en && tb != per_q) |=> $stable(idx));

  a_r5_settings_held: assert property (@(posedge clk) disable iff (rst)
    (running && en && !(wrap && last)) |=>
      ($stable(per_q) && $stable(cmp_q) && $stable(act_q) && $stable(blk_q)));

  a_r7_zero_pulses_low: assert property (@(posedge clk) disable iff (rst)
    (running && act_q == '0) |-> !pwm_out);

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
    (frame_start && en && per_q != '0) |=> !frame_start);

  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!pwm_out && !frame_start));
endmodule

// File: tb/tb_pwm_frame_blanker.sv
module tb_pwm_frame_blanker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] period_in = '0, cmp_in = '0;
  logic [7:0]  act_in = '0, blk_in = '0;
  logic        pwm_out, frame_start;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_frame_blanker dut (
    .clk(clk), .rst(rst), .en(en), .period_in(period_in), .cmp_in(cmp_in),
    .act_in(act_in), .blk_in(blk_in), .pwm_out(pwm_out), .frame_start(frame_start)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cfg(input int p, input int c, input int a, input int b,
                         input int ncyc, input bit r5);
    int mp, mc, ma, mb, ml, mph, mpos;
    bit first;
    string req;
    @(negedge clk);
    en = 1'b0;
    period_in = 16'(p); cmp_in = 16'(c); act_in = 8'(a); blk_in = 8'(b);
    @(negedge clk);
    chk(pwm_out, 1'b0, "R9 idle pwm");
    chk(frame_start, 1'b0, "R9 idle strobe");
    en = 1'b1;
    first = 1'b1;
    mp = 0; mc = 0; ma = 0; mb = 0; ml = 1; mph = 0; mpos = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk);
      if (first || (mph == mp && mpos + 1 >= ml)) begin
        mp = int'(period_in); mc = int'(cmp_in);
        ma = int'(act_in); mb = int'(blk_in);
        ml = (ma + mb > 0) ? ma + mb : 1;
        mph = 0; mpos = 0; first = 1'b0;
      end else if (mph == mp) begin
        mph = 0; mpos++;
      end else begin
        mph++;
      end
      @(negedge clk);
      if (r5)                    req = "R5 pwm";
      else if (ma == 0 || mb == 0) req = "R7 pwm";
      else if (mpos >= ma)       req = "R4 blank pwm";
      else if (mc == 0 || mc > mp) req = "R6 pwm";
      else                       req = "R1 R2 R3 pwm";
      chk(pwm_out, logic'((mpos < ma) && (mph < mc)), req);
      chk(frame_start, logic'(mph == 0 && mpos == 0), (i == 0) ? "R9 first frame" : "R8 strobe");
      if (r5 && i == 5) begin
        period_in = 16'd1; cmp_in = 16'd4; act_in = 8'd1; blk_in = 8'd3;
      end
    end
    en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pwm_out, 1'b0, "R9 reset pwm");
    chk(frame_start, 1'b0, "R9 reset strobe");
    rst = 1'b0;
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(pwm_out, 1'b0, "R9 disabled pwm");

    for (int pi = 0; pi < 4; pi++) begin
      int p;
      p = (pi == 3) ? 4 : pi;
      for (int c = 0; c <= p + 1; c++)
        for (int a = 0; a <= 3; a++)
          for (int b = 0; b <= 4; b++) begin
            int l;
            l = (a + b > 0) ? a + b : 1;
            run_cfg(p, c, a, b, 3 * l * (p + 1) + 2, 1'b0);
          end
    end
    run_cfg(3, 2, 2, 4, 80, 1'b0);
    run_cfg(3, 2, 2, 2, 60, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int w = 0; w < 150000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule